// File: doc/BRIEF.md
# Multi-mode carry-chain ALU slice

This block is a combinational arithmetic chain of parameterizable width. It is built from identical one-bit cells. Every cell gets a bit of each of two operands, a direction bit of its own and the carry from the cell below. Each cell returns one result bit and a carry for the cell above. The external carry input feeds bit 0, and the carry leaving the top bit is the block's carry output. All cells share one 4-bit function code.

The function code selects one of ten per-bit functions:

- Sums and differences with a carry or borrow.
- Mixed add/subtract under per-bit direction control.
- Comparisons whose answer is read from the final carry alone.
- Incrementers and decrementers that take no second operand and can be paused through the carry input.
- A partial-product step for building multipliers.

Integrators place the slice in datapaths that need a counter, comparator or adder built on a single ripple chain.

Top module: `alu_chain_slice`

## Requirements
- R1: Code 0 (add): {carry_out, sum} equals op_a + op_b + carry_in.
- R2: Codes 1 (subtract) and 4 (greater-or-equal) act alike: {carry_out, sum} equals op_a + ~op_b + carry_in. With carry_in = 1, carry_out is 1 exactly when op_a >= op_b.
- R3: Code 2 (mixed add/subtract): bit i adds op_b[i] when dir[i] = 1 and adds ~op_b[i] when dir[i] = 0. So {carry_out, sum} = op_a + (op_b ^ ~dir) + carry_in.
- R4: Code 3 (not-equal): the carry into bit i is carry_in OR (any lower bit of op_a differs from op_b). sum[i] is the inverse of op_a[i] ^ op_b[i] ^ that carry. With carry_in = 0, carry_out is 1 exactly when op_a != op_b.
- R5: Code 5 (less-or-equal): {carry_out, sum} equals ~op_a + op_b + carry_in. With carry_in = 1, carry_out is 1 exactly when op_a <= op_b. With carry_in = 0, carry_out is 1 exactly when op_a < op_b.
- R6: Code 6 (count up): {carry_out, sum} equals op_a + carry_in, and op_b has no effect. carry_in = 0 returns op_a with carry_out = 0.
- R7: Code 7 (count down): {carry_out, sum} equals op_a + all-ones + carry_in, and op_b has no effect. carry_in = 0 returns op_a - 1 with carry_out = 0 only when op_a = 0. carry_in = 1 returns op_a with carry_out = 1.
- R8: Code 8 (mixed count): bit i counts up when dir[i] = 1 and counts down when dir[i] = 0. So {carry_out, sum} = op_a + ~dir + carry_in.
- R9: Code 9 (partial product): with p = op_a & op_b, the carry into bit i is carry_in AND (all lower bits of p are 1). sum[i] = p[i] ^ that carry.
- R10: dir has no effect on sum or carry_out for any code other than 2 and 8.
- R11: Codes 10 to 15 drive sum and carry_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (count value in counting codes) |
| op_b | input | WIDTH | Second operand |
| dir | input | WIDTH | Per-bit direction, 1 = up/add, 0 = down/subtract |
| mode | input | 4 | Function code, 0 to 9 |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Result bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Every time the inputs settle, assertions check these behaviours:

- The full add result.
- The comparison answers of the greater-or-equal, less-or-equal and not-equal codes at their intended carry input.
- Both counter pause cases.
- The zero output of unused codes.

Only the bench's scenarios show the following:

- The bit-accurate sums of the mixed per-bit codes.
- The partial-product chain.
- The not-equal sum bits.
- That flipping dir or op_b leaves the other codes unchanged.

Those scenarios come from a behavioural reference.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;

  localparam int unsigned MODE_W = 4;

  // external function codes
  typedef enum logic [MODE_W-1:0] {
    MODE_ADD     = 4'd0,
    MODE_SUB     = 4'd1,
    MODE_ADDSUB  = 4'd2,
    MODE_NEQ     = 4'd3,
    MODE_GE      = 4'd4,
    MODE_LE      = 4'd5,
    MODE_UP      = 4'd6,
    MODE_DOWN    = 4'd7,
    MODE_UPDOWN  = 4'd8,
    MODE_MUL     = 4'd9
  } mode_e;

  // per-bit cell functions
  typedef enum logic [2:0] {
    FN_OFF = 3'd0,
    FN_ADD = 3'd1,
    FN_SUB = 3'd2,
    FN_NEQ = 3'd3,
    FN_LE  = 3'd4,
    FN_UP  = 3'd5,
    FN_DN  = 3'd6,
    FN_MUL = 3'd7
  } cell_fn_e;

  // cell function when the bit's direction is 1 / 0
  typedef struct packed {
    cell_fn_e fn_dir_hi;
    cell_fn_e fn_dir_lo;
  } cell_ctl_t;

endpackage

// File: rtl/alu_chain_decode.sv
module alu_chain_decode
  import alu_chain_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output cell_ctl_t         ctl
);

  cell_fn_e base_fn;

  always_comb begin
    base_fn = FN_OFF;
    case (mode)
      MODE_ADD:            base_fn = FN_ADD;
      MODE_SUB, MODE_GE:   base_fn = FN_SUB;
      MODE_NEQ:            base_fn = FN_NEQ;
      MODE_LE:             base_fn = FN_LE;
      MODE_UP:             base_fn = FN_UP;
      MODE_DOWN:           base_fn = FN_DN;
      MODE_MUL:            base_fn = FN_MUL;
      default:             base_fn = FN_OFF;
    endcase
  end

  // only the two mixed codes look at the direction bit
  always_comb begin
    ctl.fn_dir_hi = base_fn;
    ctl.fn_dir_lo = base_fn;
    if (mode == MODE_ADDSUB) begin
      ctl.fn_dir_hi = FN_ADD;
      ctl.fn_dir_lo = FN_SUB;
    end else if (mode == MODE_UPDOWN) begin
      ctl.fn_dir_hi = FN_UP;
      ctl.fn_dir_lo = FN_DN;
    end
  end

  // R11: decoder keeps unused codes off for either direction
  always_comb begin
    if (mode > 4'd9) begin
      assert_decode_off_R11: assert (ctl.fn_dir_hi == FN_OFF && ctl.fn_dir_lo == FN_OFF)
        else $error("unused code produced an active cell function");
    end
  end

endmodule

// File: rtl/alu_chain_cell.sv
module alu_chain_cell
  import alu_chain_pkg::*;
(
  input  cell_ctl_t ctl,
  input  logic      bit_a,
  input  logic      bit_b,
  input  logic      bit_dir,
  input  logic      c_in,
  output logic      s_out,
  output logic      c_out
);

  cell_fn_e fn;
  logic     prod;

  assign fn   = bit_dir ? ctl.fn_dir_hi : ctl.fn_dir_lo;
  assign prod = bit_a & bit_b;

  always_comb begin
    s_out = 1'b0;
    c_out = 1'b0;
    case (fn)
      FN_ADD: begin
        s_out = bit_a ^ bit_b ^ c_in;
        c_out = (bit_a & bit_b) | (bit_a & c_in) | (bit_b & c_in);
      end
      FN_SUB: begin
        s_out = ~(bit_a ^ bit_b ^ c_in);
        c_out = (bit_a & ~bit_b) | (bit_a & c_in) | (~bit_b & c_in);
      end
      FN_NEQ: begin
        s_out = ~(bit_a ^ bit_b ^ c_in);
        c_out = c_in | (bit_a ^ bit_b);
      end
      FN_LE: begin
        s_out = ~(bit_a ^ bit_b ^ c_in);
        c_out = (~bit_a & bit_b) | (~bit_a & c_in) | (bit_b & c_in);
      end
      FN_UP: begin
        s_out = bit_a ^ c_in;
        c_out = bit_a & c_in;
      end
      FN_DN: begin
        s_out = ~(bit_a ^ c_in);
        c_out = bit_a | c_in;
      end
      FN_MUL: begin
        s_out = prod ^ c_in;
        c_out = prod & c_in;
      end
      default: begin
        s_out = 1'b0;
        c_out = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_chain_slice.sv
module alu_chain_slice
  import alu_chain_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [WIDTH-1:0]  dir,
  input  logic [MODE_W-1:0] mode,
  input  logic              carry_in,
  output logic [WIDTH-1:0]  sum,
  output logic              carry_out
);

  localparam int unsigned CHAIN_W = WIDTH + 1;

  cell_ctl_t          ctl;
  logic [CHAIN_W-1:0] chain;

  alu_chain_decode u_decode (
    .mode (mode),
    .ctl  (ctl)
  );

  assign chain[0] = carry_in;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    alu_chain_cell u_cell (
      .ctl     (ctl),
      .bit_a   (op_a[gi]),
      .bit_b   (op_b[gi]),
      .bit_dir (dir[gi]),
      .c_in    (chain[gi]),
      .s_out   (sum[gi]),
      .c_out   (chain[gi+1])
    );
  end

  assign carry_out = chain[WIDTH];

  // checks on the settled port values
  always_comb begin
    if (mode == MODE_ADD) begin
      assert_add_R1: assert ({carry_out, sum} == CHAIN_W'(op_a) + CHAIN_W'(op_b) + CHAIN_W'(carry_in))
        else $error("add result mismatch");
    end
    if (mode == MODE_GE && carry_in) begin
      assert_ge_flag_R2: assert (carry_out == (op_a >= op_b))
        else $error("greater-or-equal flag mismatch");
    end
    if (mode == MODE_NEQ && !carry_in) begin
      assert_neq_flag_R4: assert (carry_out == (op_a != op_b))
        else $error("not-equal flag mismatch");
    end
    if (mode == MODE_LE && carry_in) begin
      assert_le_flag_R5: assert (carry_out == (op_a <= op_b))
        else $error("less-or-equal flag mismatch");
    end
    if (mode == MODE_UP && !carry_in) begin
      assert_up_hold_R6: assert (sum == op_a && !carry_out)
        else $error("paused up-count changed value");
    end
    if (mode == MODE_DOWN && carry_in) begin
      assert_down_hold_R7: assert (sum == op_a && carry_out)
        else $error("paused down-count changed value");
    end
    if (mode > 4'd9) begin
      assert_unused_zero_R11: assert (sum == '0 && !carry_out)
        else $error("unused code drove a nonzero output");
    end
  end

endmodule

// File: tb/test_alu_chain_slice.sv
module test_alu_chain_slice;

  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a, op_b, dir;
  logic [3:0]   mode;
  logic         carry_in;
  logic [W-1:0] sum;
  logic         carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  alu_chain_slice #(.WIDTH(W)) i_alu_chain_slice (
    .op_a      (op_a),
    .op_b      (op_b),
    .dir       (dir),
    .mode      (mode),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: {carry, sum}
  function automatic logic [W:0] ref_result(input logic [3:0] m, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [W-1:0] d,
                                            input logic c);
    logic [W:0]   ea, eb, ec;
    logic [W-1:0] mask, p, s;
    logic         cy;
    ea = {1'b0, a};
    ec = {{W{1'b0}}, c};
    s  = '0;
    cy = 1'b0;
    mask = '0;
    case (m)
      4'd0:       return ea + {1'b0, b} + ec;
      4'd1, 4'd4: return ea + {1'b0, ~b} + ec;
      4'd2:       return ea + {1'b0, b ^ ~d} + ec;
      4'd5:       return {1'b0, ~a} + {1'b0, b} + ec;
      4'd6:       return ea + ec;
      4'd7:       return ea + {1'b0, {W{1'b1}}} + ec;
      4'd8:       return ea + {1'b0, ~d} + ec;
      4'd3: begin
        for (int i = 0; i < W; i++) begin
          cy   = c | (((a ^ b) & mask) != '0);
          s[i] = ~(a[i] ^ b[i] ^ cy);
          mask[i] = 1'b1;
        end
        cy = c | (a != b);
        return {cy, s};
      end
      4'd9: begin
        p = a & b;
        for (int i = 0; i < W; i++) begin
          cy   = c & ((p & mask) == mask);
          s[i] = p[i] ^ cy;
          mask[i] = 1'b1;
        end
        cy = c & (p == {W{1'b1}});
        return {cy, s};
      end
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d a=%h b=%h dir=%h cin=%b actual=%h expected=%h",
               req, mode, op_a, op_b, dir, carry_in, got, exp);
    end
  endtask

  // drive after a rising edge, compare at the next falling edge
  task automatic apply(input string req, input logic [3:0] m, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] d, input logic c);
    @(posedge clk);
    #1;
    mode = m; op_a = a; op_b = b; dir = d; carry_in = c;
    @(negedge clk);
    check(req, {carry_out, sum}, ref_result(m, a, b, d, c));
  endtask

  // dir or op_b must not matter: compare two applications directly
  task automatic apply_pair(input string req, input logic [3:0] m, input logic [W-1:0] a,
                            input logic [W-1:0] b1, input logic [W-1:0] b2,
                            input logic [W-1:0] d1, input logic [W-1:0] d2, input logic c);
    logic [W:0] first;
    apply(req, m, a, b1, d1, c);
    first = {carry_out, sum};
    apply(req, m, a, b2, d2, c);
    check(req, {carry_out, sum}, first);
  endtask

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1, 4'd4: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode = '0; op_a = '0; op_b = '0; dir = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset-time idle", {carry_out, sum}, '0);
    rst_n = 1'b1;

    // R1 overflow and carry-in
    apply("R1 overflow", 4'd0, 16'hFFFF, 16'h0001, 16'h0, 1'b0);
    apply("R1 cin adds one", 4'd0, 16'h1234, 16'h0F0F, 16'h0, 1'b1);
    // R2 equal, less, greater
    apply("R2 ge equal", 4'd4, 16'h5555, 16'h5555, 16'h0, 1'b1);
    apply("R2 ge less", 4'd4, 16'h0003, 16'h0004, 16'h0, 1'b1);
    apply("R2 sub underflow", 4'd1, 16'h0000, 16'h0001, 16'h0, 1'b1);
    apply("R2 ge strict", 4'd4, 16'h0007, 16'h0007, 16'h0, 1'b0);
    // R3 mixed directions
    apply("R3 all add", 4'd2, 16'h00FF, 16'h0101, 16'hFFFF, 1'b0);
    apply("R3 all sub", 4'd2, 16'h00FF, 16'h0101, 16'h0000, 1'b1);
    apply("R3 mixed", 4'd2, 16'hA5A5, 16'h3C3C, 16'h00FF, 1'b0);
    // R4 equal / differing in top bit only
    apply("R4 equal", 4'd3, 16'hBEEF, 16'hBEEF, 16'h0, 1'b0);
    apply("R4 top bit differs", 4'd3, 16'h8001, 16'h0001, 16'h0, 1'b0);
    apply("R4 cin forces", 4'd3, 16'h1111, 16'h1111, 16'h0, 1'b1);
    // R5 equal with both carry values
    apply("R5 le equal", 4'd5, 16'h4242, 16'h4242, 16'h0, 1'b1);
    apply("R5 lt equal", 4'd5, 16'h4242, 16'h4242, 16'h0, 1'b0);
    apply("R5 le greater", 4'd5, 16'h4243, 16'h4242, 16'h0, 1'b1);
    // R6 / R7 counting edges and operand-B independence
    apply("R6 wrap", 4'd6, 16'hFFFF, 16'h1234, 16'h0, 1'b1);
    apply("R6 hold", 4'd6, 16'h00AA, 16'hFFFF, 16'h0, 1'b0);
    apply_pair("R6 b ignored", 4'd6, 16'h0F0F, 16'h0000, 16'hFFFF, 16'h0, 16'h0, 1'b1);
    apply("R7 underflow", 4'd7, 16'h0000, 16'h5A5A, 16'h0, 1'b0);
    apply("R7 hold", 4'd7, 16'h0033, 16'h0000, 16'h0, 1'b1);
    apply_pair("R7 b ignored", 4'd7, 16'h0100, 16'h0000, 16'hFFFF, 16'h0, 16'h0, 1'b0);
    // R8 mixed counting
    apply("R8 all up", 4'd8, 16'h00FF, 16'h0, 16'hFFFF, 1'b1);
    apply("R8 all down", 4'd8, 16'h0100, 16'h0, 16'h0000, 1'b0);
    apply("R8 mixed", 4'd8, 16'h1357, 16'h0, 16'hF0F0, 1'b1);
    // R9 partial product
    apply("R9 full ripple", 4'd9, 16'hFFFF, 16'hFFFF, 16'h0, 1'b1);
    apply("R9 broken", 4'd9, 16'hFF0F, 16'hFFFF, 16'h0, 1'b1);
    apply("R9 no cin", 4'd9, 16'hC3C3, 16'hF00F, 16'h0, 1'b0);
    // R10 dir ignored elsewhere
    for (int m = 0; m < 10; m++) begin
      if (m != 2 && m != 8)
        apply_pair("R10 dir ignored", 4'(m), 16'h6D2B, 16'h19E4, 16'h19E4, 16'h0000, 16'hFFFF, 1'b1);
    end
    // R11 unused codes
    for (int m = 10; m < 16; m++)
      apply("R11 unused", 4'(m), 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1);

    // sweep of mixed patterns
    for (int k = 0; k < 400; k++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      apply(tag(m), m, 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule